// File: doc/BRIEF.md
# Status LED Multiplexer with Blink Patterns

This block drives a board's status indicators: a green and a red status LED, two LED pin pairs (each with a negative and a positive pin), and a configuration-done LED. While a remote link is active, six of these outputs take their values from fixed bits of a remote GPIO word. Some of those bits are used inverted. When the link drops, each output falls back to a local status value. That value comes from the power-on request, the reset button level, or one of two internally generated waveforms.

The first waveform is a slow 50% duty square wave. Its half period is set by a parameter, so the default gives about 1 Hz at a 200 MHz clock. The second waveform encodes the 2-bit boot mode as a burst of short pulses followed by a pause, repeated without end. The boot mode is sampled only at frame boundaries, so a burst is never torn by a mode change. All outputs come from registers, so switching between remote values and fallback values cannot glitch the pins.

Top module: `led_status_mux`

## Requirements
- R1: While `link_active` is 1, `led_green` equals `remote_io[5]`. While it is 0, `led_green` is 1 if `power_req` is 1 and carries the slow-blink wave if `power_req` is 0.
- R2: While `link_active` is 1, `led_red` equals `remote_io[6]`. While it is 0, `led_red` is the OR of the inverted `rst_key` (1 = button pressed) and the mode-blink wave.
- R3: `pair_a_neg` equals `remote_io[7]` while the link is active, and is 0 otherwise.
- R4: `pair_a_pos` equals the inverse of `remote_io[8]` while the link is active. Otherwise it follows the same rule as the green LED fallback (1 with `power_req` high, slow-blink with it low) and is in phase with `led_green`.
- R5: `pair_b_neg` equals `remote_io[9]` while the link is active, and is 0 otherwise.
- R6: `pair_b_pos` equals the inverse of `remote_io[10]` while the link is active, and equals `rst_key` otherwise.
- R7: `led_cfg` equals the inverse of `prog_done`, whatever the link state is.
- R8: The slow-blink wave is a square wave that holds each level for exactly `SLOW_HALF_CYC` clock cycles.
- R9: The mode-blink wave repeats a frame of `2*(m+1)+PAUSE_SLOTS` slots of `SLOT_CYC` cycles each, where m is the latched boot mode. Slots 0, 2, …, 2m are high and all other slots are low, so each frame carries m+1 pulses.
- R10: The boot mode is latched only at the end of a frame. A new mode value shows up in the pulse count within one frame of the longest mode.
- R11: Every output changes exactly one clock cycle after the input change that causes it. During synchronous reset (`rst` = 1), all outputs are 0.
- R12: Bits of `remote_io` other than 5 to 10 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| remote_io | input | GPIO_W | Remote GPIO word; bits 5 to 10 drive the overrides |
| link_active | input | 1 | Remote link active; selects the remote values |
| power_req | input | 1 | Power-on request level |
| rst_key | input | 1 | Reset button, 1 = pressed |
| boot_mode | input | MODE_W | Boot mode shown by the mode-blink pattern |
| prog_done | input | 1 | Device programming complete |
| led_green | output | 1 | Green status LED |
| led_red | output | 1 | Red status LED |
| pair_a_neg | output | 1 | First LED pair, negative pin |
| pair_a_pos | output | 1 | First LED pair, positive pin |
| pair_b_neg | output | 1 | Disk LED pair, negative pin |
| pair_b_pos | output | 1 | Disk LED pair, positive pin |
| led_cfg | output | 1 | Configuration-done LED (lit while unprogrammed) |

## Verification
The red LED is where two functions meet in the same cycle: the reset-button term and the mode-blink pulse are ORed into one register. The bench first holds the button released, and the red LED must then stay lit steadily even though the mode pattern keeps running underneath. It then presses the button, and the pulses must appear with exactly m+1 rising edges and (m+1)·SLOT_CYC high cycles per frame. Boot-mode changes are applied in the middle of a frame. Counting starts only after one longest frame has passed, so the count shows that the new mode was taken at a boundary and not mid-burst.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

    // Number of LEDs that a remote GPIO bit can override
    localparam int unsigned NUM_OVR = 6;

    // Slot order inside the override vector
    typedef enum logic [2:0] {
        SLOT_GREEN = 3'd0,
        SLOT_RED   = 3'd1,
        SLOT_A_NEG = 3'd2,
        SLOT_A_POS = 3'd3,
        SLOT_B_NEG = 3'd4,
        SLOT_B_POS = 3'd5
    } led_slot_e;

    // Remote GPIO bit that controls a given slot
    function automatic int unsigned ovr_bit(input int unsigned slot);
        return 5 + slot;
    endfunction

    // Slots whose remote value is shown inverted
    function automatic bit ovr_inv(input int unsigned slot);
        return (slot == 32'(SLOT_A_POS)) || (slot == 32'(SLOT_B_POS));
    endfunction

    typedef struct packed {
        logic               cfg;
        logic [NUM_OVR-1:0] ovr;
    } led_vec_t;

endpackage

// File: rtl/led_slow_blink.sv
module led_slow_blink #(
    parameter int unsigned HALF_CYC = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic wave
);
    localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          wave;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.wave = ~st_q.wave;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wave = st_q.wave;

    // R8
    wave_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.wave != $past(st_q.wave)) |-> ($past(st_q.cnt) == LAST));

endmodule

// File: rtl/led_mode_blink.sv
module led_mode_blink #(
    parameter int unsigned SLOT_CYC    = 20_000_000,
    parameter int unsigned PAUSE_SLOTS = 6,
    parameter int unsigned MODE_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    output logic              pulse
);
    localparam int unsigned MAX_FRAME = 2 * (1 << MODE_W) + PAUSE_SLOTS;
    localparam int unsigned IW        = $clog2(MAX_FRAME + 1);
    localparam int unsigned CW        = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [CW-1:0] SLOT_LAST = CW'(SLOT_CYC - 1);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [IW-1:0]     idx;
        logic [MODE_W-1:0] mode;
        logic              pulse;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [IW-1:0] burst_len(input logic [MODE_W-1:0] m);
        return IW'({m, 1'b0}) + IW'(2);
    endfunction

    function automatic logic [IW-1:0] frame_last(input logic [MODE_W-1:0] m);
        return burst_len(m) + IW'(PAUSE_SLOTS - 1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == SLOT_LAST) begin
            st_d.cnt = '0;
            if (st_q.idx == frame_last(st_q.mode)) begin
                st_d.idx  = '0;
                st_d.mode = mode;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.pulse = (st_d.idx < burst_len(st_d.mode)) && !st_d.idx[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.pulse <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;

    // R10
    mode_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode != $past(st_q.mode)) |-> (st_q.idx == '0 && st_q.cnt == '0));

    // R9
    pulse_slot_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.pulse) |-> (st_q.cnt == '0));

endmodule

// File: rtl/led_out_mux.sv
module led_out_mux
    import led_status_pkg::*;
#(
    parameter int unsigned GPIO_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [GPIO_W-1:0]  gpio,
    input  logic               link,
    input  logic [NUM_OVR-1:0] local_val,
    input  logic               prog_done,
    output led_vec_t           leds
);
    initial assert (GPIO_W >= 11);

    typedef struct packed {
        logic     live;
        led_vec_t v;
    } st_t;

    st_t st_d, st_q;
    logic [NUM_OVR-1:0] sel;
    logic unused_gpio;

    assign unused_gpio = ^gpio;

    for (genvar i = 0; i < NUM_OVR; i++) begin : g_sel
        localparam int unsigned BIT = ovr_bit(i);
        localparam bit          INV = ovr_inv(i);
        assign sel[i] = link ? (gpio[BIT] ^ INV) : local_val[i];
    end

    always_comb begin
        st_d       = st_q;
        st_d.live  = 1'b1;
        st_d.v.ovr = sel;
        st_d.v.cfg = ~prog_done;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign leds = st_q.v;

    // R1
    green_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.live && $past(link)) |-> (leds.ovr[SLOT_GREEN] == $past(gpio[5])));

    // R4
    apos_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.live && $past(link)) |-> (leds.ovr[SLOT_A_POS] == !$past(gpio[8])));

    // R3
    aneg_off_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.live && !$past(link)) |-> !leds.ovr[SLOT_A_NEG]);

    // R5
    bneg_off_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.live && !$past(link)) |-> !leds.ovr[SLOT_B_NEG]);

    // R7
    cfg_led_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.live |-> (leds.cfg == !$past(prog_done)));

endmodule

// File: rtl/led_status_mux.sv
module led_status_mux
    import led_status_pkg::*;
#(
    parameter int unsigned GPIO_W        = 32,
    parameter int unsigned MODE_W        = 2,
    parameter int unsigned SLOW_HALF_CYC = 100_000_000,
    parameter int unsigned SLOT_CYC      = 20_000_000,
    parameter int unsigned PAUSE_SLOTS   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GPIO_W-1:0] remote_io,
    input  logic              link_active,
    input  logic              power_req,
    input  logic              rst_key,
    input  logic [MODE_W-1:0] boot_mode,
    input  logic              prog_done,
    output logic              led_green,
    output logic              led_red,
    output logic              pair_a_neg,
    output logic              pair_a_pos,
    output logic              pair_b_neg,
    output logic              pair_b_pos,
    output logic              led_cfg
);
    logic               slow_wave;
    logic               mode_wave;
    logic [NUM_OVR-1:0] local_val;
    led_vec_t           leds;

    led_slow_blink #(
        .HALF_CYC (SLOW_HALF_CYC)
    ) u_slow (
        .clk  (clk),
        .rst  (rst),
        .wave (slow_wave)
    );

    led_mode_blink #(
        .SLOT_CYC    (SLOT_CYC),
        .PAUSE_SLOTS (PAUSE_SLOTS),
        .MODE_W      (MODE_W)
    ) u_mode (
        .clk   (clk),
        .rst   (rst),
        .mode  (boot_mode),
        .pulse (mode_wave)
    );

    always_comb begin
        local_val             = '0;
        local_val[SLOT_GREEN] = power_req | slow_wave;
        local_val[SLOT_RED]   = ~rst_key | mode_wave;
        local_val[SLOT_A_NEG] = 1'b0;
        local_val[SLOT_A_POS] = power_req | slow_wave;
        local_val[SLOT_B_NEG] = 1'b0;
        local_val[SLOT_B_POS] = rst_key;
    end

    led_out_mux #(
        .GPIO_W (GPIO_W)
    ) u_mux (
        .clk       (clk),
        .rst       (rst),
        .gpio      (remote_io),
        .link      (link_active),
        .local_val (local_val),
        .prog_done (prog_done),
        .leds      (leds)
    );

    assign led_green  = leds.ovr[SLOT_GREEN];
    assign led_red    = leds.ovr[SLOT_RED];
    assign pair_a_neg = leds.ovr[SLOT_A_NEG];
    assign pair_a_pos = leds.ovr[SLOT_A_POS];
    assign pair_b_neg = leds.ovr[SLOT_B_NEG];
    assign pair_b_pos = leds.ovr[SLOT_B_POS];
    assign led_cfg    = leds.cfg;

    // R6
    bpos_local_chk: assert property (@(posedge clk) disable iff (rst)
        (!link_active && $stable(link_active) && $stable(rst_key)) |=> (pair_b_pos == $past(rst_key)));

endmodule

// File: tb/led_status_mux_test.sv
`timescale 1ns/1ps
module led_status_mux_test;

    localparam int unsigned SLOW = 8;
    localparam int unsigned SLOT = 3;
    localparam int unsigned PAUSE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] remote_io = '0;
    logic        link_active = 1'b0;
    logic        power_req = 1'b0;
    logic        rst_key = 1'b0;
    logic [1:0]  boot_mode = '0;
    logic        prog_done = 1'b0;
    logic        led_green, led_red, pair_a_neg, pair_a_pos, pair_b_neg, pair_b_pos, led_cfg;

    always #2.5 clk = ~clk;

    led_status_mux #(
        .GPIO_W(32), .MODE_W(2), .SLOW_HALF_CYC(SLOW), .SLOT_CYC(SLOT), .PAUSE_SLOTS(PAUSE)
    ) uut (
        .clk(clk), .rst(rst), .remote_io(remote_io), .link_active(link_active),
        .power_req(power_req), .rst_key(rst_key), .boot_mode(boot_mode), .prog_done(prog_done),
        .led_green(led_green), .led_red(led_red), .pair_a_neg(pair_a_neg), .pair_a_pos(pair_a_pos),
        .pair_b_neg(pair_b_neg), .pair_b_pos(pair_b_pos), .led_cfg(led_cfg)
    );

    // bit order: cfg, b_pos, b_neg, a_pos, a_neg, red, green
    wire [6:0] obs = {led_cfg, pair_b_pos, pair_b_neg, pair_a_pos, pair_a_neg, led_red, led_green};

    typedef struct {
        logic [6:0] exp;
        logic [6:0] mask;
        string      tag;
    } item_t;

    item_t sb[$];
    int    errors = 0;
    int    checks = 0;
    bit    finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Scoreboard monitor: one item per cycle, compared one cycle after it was driven
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if ((obs & it.mask) !== (it.exp & it.mask)) begin
                    errors++;
                    $display("FAIL %s: actual %b expected %b (mask %b)", it.tag, obs, it.exp, it.mask);
                end
            end
        end
    end

    // Expected outputs from the requirements; blinking pins are masked
    function automatic item_t model(input logic [31:0] g, input logic lnk, input logic pw,
                                    input logic key, input logic dn, input string tag);
        item_t it;
        it.tag = tag;
        it.mask = 7'h7f;
        it.exp = '0;
        if (lnk) begin
            it.exp[0] = g[5];
            it.exp[1] = g[6];
            it.exp[2] = g[7];
            it.exp[3] = ~g[8];
            it.exp[4] = g[9];
            it.exp[5] = ~g[10];
        end else begin
            it.exp[0] = 1'b1;  it.mask[0] = pw;
            it.exp[1] = 1'b1;  it.mask[1] = ~key;
            it.exp[2] = 1'b0;
            it.exp[3] = 1'b1;  it.mask[3] = pw;
            it.exp[4] = 1'b0;
            it.exp[5] = key;
        end
        it.exp[6] = ~dn;
        return it;
    endfunction

    task automatic drive(input logic [31:0] g, input logic lnk, input logic pw, input logic key,
                         input logic [1:0] md, input logic dn, input string tag);
        @(negedge clk);
        #1;
        remote_io = g; link_active = lnk; power_req = pw; rst_key = key;
        boot_mode = md; prog_done = dn;
        sb.push_back(model(g, lnk, pw, key, dn, tag));
    endtask

    task automatic measure_slow(input int n, output int highs, output int edges, output int diff);
        logic prev;
        highs = 0; edges = 0; diff = 0;
        @(negedge clk);
        prev = led_green;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (led_green) highs++;
            if (led_green != prev) edges++;
            if (pair_a_pos != led_green) diff++;
            prev = led_green;
        end
    endtask

    task automatic measure_red(input int n, output int highs, output int rises);
        logic prev;
        highs = 0; rises = 0;
        @(negedge clk);
        prev = led_red;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (led_red) highs++;
            if (led_red && !prev) rises++;
            prev = led_red;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int hi, ed, df, ri;
        item_t rs;

        // R11 reset state: all outputs low while reset is held
        remote_io = 32'hffff_ffff; link_active = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        rs.exp = '0; rs.mask = 7'h7f; rs.tag = "R11 reset state";
        sb.push_back(rs);
        @(negedge clk);
        #1 rst = 1'b0;

        // Overrides with link active, several patterns
        drive(32'h0000_0000, 1, 0, 0, 0, 0, "R1 R2 R3 R4 R5 R6 override zeros");
        drive(32'hffff_ffff, 1, 0, 0, 0, 1, "R1 R2 R3 R4 R5 R6 override ones");
        drive(32'h0000_02a0, 1, 0, 0, 0, 1, "R1 R3 R5 override odd bits");
        drive(32'h0000_0540, 1, 1, 1, 2, 0, "R2 R4 R6 override even bits");
        drive(32'h0000_0020, 1, 0, 1, 3, 0, "R1 single bit 5");
        drive(32'h0000_0400, 1, 0, 1, 3, 0, "R6 single bit 10");
        // R12: every bit outside 5..10 set, must look like all zeros
        drive(32'hffff_f81f, 1, 0, 0, 0, 0, "R12 unrelated bits ignored");
        drive(32'hffff_f81f, 1, 1, 1, 1, 1, "R12 unrelated bits ignored other inputs");

        // R7 configuration LED independent of the link
        drive(32'h0, 0, 1, 0, 0, 0, "R7 unprogrammed link off");
        drive(32'h0, 0, 1, 0, 0, 1, "R7 programmed link off");

        // Local fallbacks, power on, button released: steady values
        drive(32'hffff_ffff, 0, 1, 0, 0, 1, "R1 R2 R3 R4 R5 R6 fallback released");
        drive(32'hffff_ffff, 0, 1, 1, 0, 1, "R3 R5 R6 fallback pressed");
        drive(32'h0000_0000, 0, 1, 0, 0, 1, "R11 one-cycle latency back to released");
        drive(32'h0000_0540, 1, 1, 0, 0, 1, "R11 one-cycle latency link on");
        drive(32'h0000_0540, 0, 1, 0, 0, 1, "R11 one-cycle latency link off");

        // R8 slow blink: power off, link off
        drive(32'h0, 0, 0, 0, 0, 1, "R1 R4 slow blink entry");
        repeat (3) @(negedge clk);
        measure_slow(8 * SLOW, hi, ed, df);
        check(hi == 4 * SLOW, "R8 slow blink high cycles", hi, 4 * SLOW);
        check(ed == 8, "R8 slow blink transitions", ed, 8);
        check(df == 0, "R4 positive pin in phase with green", df, 0);

        // R2 R9 R10 mode blink on red, button pressed
        for (int m = 0; m < 4; m++) begin
            int md;
            int frame;
            md = (m == 1) ? 3 : (m == 3) ? 1 : m;
            frame = (2 * (md + 1) + PAUSE) * SLOT;
            drive(32'h0, 0, 1, 1, 2'(md), 1, "R2 mode blink entry");
            repeat (45) @(negedge clk);
            measure_red(2 * frame, hi, ri);
            check(ri == 2 * (md + 1), "R9 R10 pulses per two frames", ri, 2 * (md + 1));
            check(hi == 2 * (md + 1) * SLOT, "R9 pulse high cycles", hi, 2 * (md + 1) * SLOT);
        end

        // R2 released button masks the pattern: red steady high
        drive(32'h0, 0, 1, 0, 3, 1, "R2 released button");
        repeat (2) @(negedge clk);
        measure_red(72, hi, ri);
        check(hi == 72, "R2 red steady while released", hi, 72);

        // R2 link active suppresses the pattern
        drive(32'h0, 1, 1, 1, 3, 1, "R2 link overrides pattern");
        repeat (2) @(negedge clk);
        measure_red(72, hi, ri);
        check(hi == 0, "R2 red follows remote bit 6 low", hi, 0);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule